// File: doc/BRIEF.md
# 100BASE-X Receive Stream Framer

This block sits behind the code-group aligner of a 100 Mb/s receive path. It accepts one aligned 5-bit code group per accepted clock, qualified by a valid strobe. It turns the stream into MII-style receive signals: a 4-bit data nibble, data valid, receive error and carrier sense.

The block finds the start-of-stream pair (J then K) and the end-of-stream pair (T then R), and decodes the sixteen 4B/5B data groups. Invalid groups inside a frame are replaced by a fixed error nibble. A frame that falls back to idle without its end pair is closed with a one-slot error marker. A J that is not followed by K is reported as a false carrier.

Each group is classified with one group of lookahead. The outputs that describe a group therefore appear at the clock edge that accepts the next group. This lookahead lets the J slot know whether K follows, and lets the T slot know whether R follows. The framing machine has five states:
- `ST_IDLE` waits for J.
- `ST_SSD_K` emits the K slot.
- `ST_DATA` carries the frame.
- `ST_EOS` swallows R.
- `ST_FALSE` waits out a false carrier.

The transitions are:
- `ST_IDLE`→`ST_SSD_K` on J with K next.
- `ST_IDLE`→`ST_FALSE` on J with anything else next.
- `ST_SSD_K`→`ST_DATA` always.
- `ST_DATA`→`ST_EOS` on T with R next.
- `ST_DATA`→`ST_IDLE` on idle.
- `ST_EOS`→`ST_IDLE` always.
- `ST_FALSE`→`ST_IDLE` on idle.

Top module: `rxfr_top`

## Requirements
- R1: A synchronous active-high reset clears all four outputs (nibble 0000, valid, error and carrier sense low), returns the machine to waiting for J and loads the pending group with idle 11111.
- R2: Inside a frame, a data group produces its nibble with data valid and carrier sense high and error low. Codes for nibbles 0 to F: 11110, 01001, 10100, 10101, 01010, 01011, 01110, 01111, 10010, 10011, 10110, 10111, 11010, 11011, 11100, 11101.
- R3: J (11000) followed by K (10001) starts a frame. The J slot and the K slot each output nibble 0101 with data valid and carrier sense high.
- R4: T (01101) followed by R (00111) ends a frame. The T and R slots output nibble 0000 with data valid, carrier sense and error low.
- R5: Idle (11111) inside a frame, with no T/R before it, ends the frame. Its slot has carrier sense and data valid low, nibble 0000, and error high for that one slot only.
- R6: Any other group inside a frame produces nibble 1110 with error, data valid and carrier sense high, and the frame continues. Such groups are J, K, R, H (00100), T not followed by R, and unused codes.
- R7: J followed by anything but K is a false carrier. The J slot has error high and carrier sense and data valid low, the error lasts one slot, and the block ignores groups until the next idle.
- R8: While the valid strobe is low, state and all outputs hold, whatever the group input carries.
- R9: The outputs for a group appear at the clock edge that accepts the group after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| code_vld | input | 1 | Code group strobe; a group is accepted on an edge where this is high |
| code_in | input | 5 | Aligned 5-bit code group |
| rx_nib | output | 4 | Receive data nibble |
| rx_dv | output | 1 | Receive data valid |
| rx_er | output | 1 | Receive error |
| rx_crs | output | 1 | Carrier sense |

## Verification
The bench places every one of the 32 code values inside a frame, just before a T. A design with a wrong table entry, or one that let an idle group decode as error data, would show a wrong nibble or flag in that slot. The same sweep catches a design that closed on T without looking for R. Every code also follows a lone J, which catches a design that raised carrier sense on J alone or held the false-carrier error past one slot. Stalls in mid frame with changing input groups catch a design that lets an unqualified group into state. A reset in mid frame catches a design that keeps carrier sense or the pending group across reset.

// File: rtl/rxfr_pkg.sv
package rxfr_pkg;

    localparam int GRP_W = 5;
    localparam int NIB_W = 4;
    localparam int N_DEC = 2;

    localparam logic [GRP_W-1:0] CG_J    = 5'b11000;
    localparam logic [GRP_W-1:0] CG_K    = 5'b10001;
    localparam logic [GRP_W-1:0] CG_T    = 5'b01101;
    localparam logic [GRP_W-1:0] CG_R    = 5'b00111;
    localparam logic [GRP_W-1:0] CG_IDLE = 5'b11111;

    localparam logic [NIB_W-1:0] NIB_PRE  = 4'b0101;
    localparam logic [NIB_W-1:0] NIB_BAD  = 4'b1110;
    localparam logic [NIB_W-1:0] NIB_ZERO = '0;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SSD_K,
        ST_DATA,
        ST_EOS,
        ST_FALSE
    } fr_state_t;

    typedef struct packed {
        logic             is_data;
        logic             is_j;
        logic             is_k;
        logic             is_t;
        logic             is_r;
        logic             is_idle;
        logic [NIB_W-1:0] nib;
    } grp_info_t;

endpackage

// File: rtl/rxfr_decode.sv
module rxfr_decode
    import rxfr_pkg::*;
(
    input  logic [GRP_W-1:0] grp,
    output grp_info_t        info
);

    always_comb begin
        info         = '0;
        info.is_j    = (grp == CG_J);
        info.is_k    = (grp == CG_K);
        info.is_t    = (grp == CG_T);
        info.is_r    = (grp == CG_R);
        info.is_idle = (grp == CG_IDLE);
        info.is_data = 1'b1;
        case (grp)
            5'b11110: info.nib = 4'h0;
            5'b01001: info.nib = 4'h1;
            5'b10100: info.nib = 4'h2;
            5'b10101: info.nib = 4'h3;
            5'b01010: info.nib = 4'h4;
            5'b01011: info.nib = 4'h5;
            5'b01110: info.nib = 4'h6;
            5'b01111: info.nib = 4'h7;
            5'b10010: info.nib = 4'h8;
            5'b10011: info.nib = 4'h9;
            5'b10110: info.nib = 4'hA;
            5'b10111: info.nib = 4'hB;
            5'b11010: info.nib = 4'hC;
            5'b11011: info.nib = 4'hD;
            5'b11100: info.nib = 4'hE;
            5'b11101: info.nib = 4'hF;
            default: begin
                info.nib     = NIB_ZERO;
                info.is_data = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/rxfr_pend.sv
module rxfr_pend
    import rxfr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             vld,
    input  logic [GRP_W-1:0] grp_in,
    output logic [GRP_W-1:0] grp_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            grp_q <= CG_IDLE;
        end else if (vld) begin
            grp_q <= grp_in;
        end
    end

endmodule

// File: rtl/rxfr_fsm.sv
module rxfr_fsm
    import rxfr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             vld,
    input  grp_info_t        cur,
    input  grp_info_t        ahead,
    output logic [NIB_W-1:0] nib_q,
    output logic             dv_q,
    output logic             er_q,
    output logic             crs_q
);

    fr_state_t        st, st_n;
    logic [NIB_W-1:0] nib_n;
    logic             dv_n, er_n, crs_n;

    always_comb begin
        st_n  = st;
        nib_n = NIB_ZERO;
        dv_n  = 1'b0;
        er_n  = 1'b0;
        crs_n = 1'b0;
        unique case (st)
            ST_IDLE: begin
                if (cur.is_j) begin
                    if (ahead.is_k) begin
                        nib_n = NIB_PRE;
                        dv_n  = 1'b1;
                        crs_n = 1'b1;
                        st_n  = ST_SSD_K;
                    end else begin
                        er_n  = 1'b1;
                        st_n  = ST_FALSE;
                    end
                end
            end
            ST_SSD_K: begin
                nib_n = NIB_PRE;
                dv_n  = 1'b1;
                crs_n = 1'b1;
                st_n  = ST_DATA;
            end
            ST_DATA: begin
                if (cur.is_t && ahead.is_r) begin
                    st_n = ST_EOS;
                end else if (cur.is_idle) begin
                    er_n = 1'b1;
                    st_n = ST_IDLE;
                end else if (cur.is_data) begin
                    nib_n = cur.nib;
                    dv_n  = 1'b1;
                    crs_n = 1'b1;
                end else begin
                    nib_n = NIB_BAD;
                    dv_n  = 1'b1;
                    er_n  = 1'b1;
                    crs_n = 1'b1;
                end
            end
            ST_EOS: begin
                st_n = ST_IDLE;
            end
            ST_FALSE: begin
                if (cur.is_idle) begin
                    st_n = ST_IDLE;
                end
            end
            default: begin
                st_n = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= ST_IDLE;
        end else if (vld) begin
            st <= st_n;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            nib_q <= NIB_ZERO;
            dv_q  <= 1'b0;
            er_q  <= 1'b0;
            crs_q <= 1'b0;
        end else if (vld) begin
            nib_q <= nib_n;
            dv_q  <= dv_n;
            er_q  <= er_n;
            crs_q <= crs_n;
        end
    end

endmodule

// File: rtl/rxfr_top.sv
module rxfr_top
    import rxfr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             code_vld,
    input  logic [GRP_W-1:0] code_in,
    output logic [NIB_W-1:0] rx_nib,
    output logic             rx_dv,
    output logic             rx_er,
    output logic             rx_crs
);

    logic [GRP_W-1:0] pend_q;
    logic [GRP_W-1:0] dec_in  [N_DEC];
    grp_info_t        dec_out [N_DEC];

    rxfr_pend u_pend (
        .clk    (clk),
        .rst    (rst),
        .vld    (code_vld),
        .grp_in (code_in),
        .grp_q  (pend_q)
    );

    // slot 0 decodes the pending group, slot 1 the lookahead group
    for (genvar g = 0; g < N_DEC; g++) begin : g_dec
        if (g == 0) begin : g_cur
            assign dec_in[g] = pend_q;
        end else begin : g_ahead
            assign dec_in[g] = code_in;
        end
        rxfr_decode u_dec (
            .grp  (dec_in[g]),
            .info (dec_out[g])
        );
    end

    rxfr_fsm u_fsm (
        .clk   (clk),
        .rst   (rst),
        .vld   (code_vld),
        .cur   (dec_out[0]),
        .ahead (dec_out[1]),
        .nib_q (rx_nib),
        .dv_q  (rx_dv),
        .er_q  (rx_er),
        .crs_q (rx_crs)
    );

endmodule

// File: rtl/rxfr_checker.sv
module rxfr_checker
    import rxfr_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             code_vld,
    input logic [GRP_W-1:0] code_in,
    input logic [NIB_W-1:0] rx_nib,
    input logic             rx_dv,
    input logic             rx_er,
    input logic             rx_crs
);

    p_reset_clears_r1: assert property (@(posedge clk)
        rst |=> (rx_nib == NIB_ZERO && !rx_dv && !rx_er && !rx_crs));

    p_dv_needs_crs_r2: assert property (@(posedge clk) disable iff (rst)
        rx_dv |-> rx_crs);

    p_start_preamble_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(rx_crs) |-> (rx_dv && !rx_er && rx_nib == NIB_PRE));

    p_clean_end_r4: assert property (@(posedge clk) disable iff (rst)
        ($fell(rx_crs) && !rx_er) |-> (!rx_dv && rx_nib == NIB_ZERO));

    p_err_outside_r5: assert property (@(posedge clk) disable iff (rst)
        (rx_er && !rx_dv) |-> (!rx_crs && rx_nib == NIB_ZERO));

    p_bad_group_r6: assert property (@(posedge clk) disable iff (rst)
        (rx_er && rx_dv) |-> (rx_nib == NIB_BAD));

    p_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !code_vld |=> ($stable(rx_nib) && $stable(rx_dv) && $stable(rx_er) && $stable(rx_crs)));

endmodule

bind rxfr_top rxfr_checker i_chk (
    .clk      (clk),
    .rst      (rst),
    .code_vld (code_vld),
    .code_in  (code_in),
    .rx_nib   (rx_nib),
    .rx_dv    (rx_dv),
    .rx_er    (rx_er),
    .rx_crs   (rx_crs)
);

// File: tb/test_rxfr_top.sv
`timescale 1ns/1ps
module test_rxfr_top;

    localparam logic [4:0] GJ = 5'b11000, GK = 5'b10001, GT = 5'b01101,
                           GR = 5'b00111, GI = 5'b11111;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       code_vld = 1'b0;
    logic [4:0] code_in = 5'b11111;
    logic [3:0] rx_nib;
    logic       rx_dv, rx_er, rx_crs;
    int         n_cmp = 0;
    int         n_bad = 0;
    bit         done = 1'b0;

    always #4 clk = ~clk;

    rxfr_top i_rxfr_top (
        .clk      (clk),
        .rst      (rst),
        .code_vld (code_vld),
        .code_in  (code_in),
        .rx_nib   (rx_nib),
        .rx_dv    (rx_dv),
        .rx_er    (rx_er),
        .rx_crs   (rx_crs)
    );

    function automatic logic [4:0] enc(input int n);
        case (n)
            0: enc = 5'b11110;  1: enc = 5'b01001;  2: enc = 5'b10100;  3: enc = 5'b10101;
            4: enc = 5'b01010;  5: enc = 5'b01011;  6: enc = 5'b01110;  7: enc = 5'b01111;
            8: enc = 5'b10010;  9: enc = 5'b10011; 10: enc = 5'b10110; 11: enc = 5'b10111;
           12: enc = 5'b11010; 13: enc = 5'b11011; 14: enc = 5'b11100; default: enc = 5'b11101;
        endcase
    endfunction

    // returns nibble index of a data code, or -1
    function automatic int dec_idx(input logic [4:0] c);
        dec_idx = -1;
        for (int n = 0; n < 16; n++) if (enc(n) == c) dec_idx = n;
    endfunction

    task automatic chk(input logic [3:0] en, input logic ed, input logic ee,
                       input logic ec, input string tag);
        n_cmp++;
        if ({rx_nib, rx_dv, rx_er, rx_crs} !== {en, ed, ee, ec}) begin
            n_bad++;
            $display("FAIL %s: got nib=%b dv=%b er=%b crs=%b, expected nib=%b dv=%b er=%b crs=%b",
                     tag, rx_nib, rx_dv, rx_er, rx_crs, en, ed, ee, ec);
        end
    endtask

    // accept one group, then check the slot of the previous group (R9)
    task automatic feed(input logic [4:0] c, input logic [3:0] en, input logic ed,
                        input logic ee, input logic ec, input string tag);
        @(negedge clk);
        code_in  = c;
        code_vld = 1'b1;
        @(posedge clk);
        #1;
        chk(en, ed, ee, ec, tag);
    endtask

    task automatic stall(input int n);
        logic [3:0] sn;
        logic       sd, se, sc;
        sn = rx_nib; sd = rx_dv; se = rx_er; sc = rx_crs;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            code_vld = 1'b0;
            code_in  = (i % 2 == 0) ? GI : GJ;
            @(posedge clk);
            #1;
            chk(sn, sd, se, sc, "R8 hold while strobe low");
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst      = 1'b1;
        code_vld = 1'b0;
        repeat (2) @(posedge clk);
        #1;
        chk(4'b0000, 1'b0, 1'b0, 1'b0, "R1 reset state");
        @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            n_cmp++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        do_reset();

        // R2 R3 R4 R9: clean frame carrying all sixteen nibbles
        feed(GI, 4'b0000, 0, 0, 0, "R1 idle slot");
        feed(GJ, 4'b0000, 0, 0, 0, "R1 idle before J");
        feed(GK, 4'b0101, 1, 0, 1, "R3 J slot");
        feed(enc(0), 4'b0101, 1, 0, 1, "R3 K slot");
        for (int i = 1; i < 16; i++)
            feed(enc(i), 4'(i - 1), 1, 0, 1, "R2 data nibble");
        feed(GT, 4'hF, 1, 0, 1, "R2 last data nibble");
        feed(GR, 4'b0000, 0, 0, 0, "R4 T slot");
        feed(GI, 4'b0000, 0, 0, 0, "R4 R slot");
        feed(GI, 4'b0000, 0, 0, 0, "R4 idle after frame");

        // R2 R5 R6: every code as the one group of a frame, then T R
        for (int v = 0; v < 32; v++) begin
            logic [4:0] c;
            int         d;
            c = 5'(v);
            d = dec_idx(c);
            feed(GJ, 4'b0000, 0, 0, 0, "R1 idle before J");
            feed(GK, 4'b0101, 1, 0, 1, "R3 J slot");
            feed(c, 4'b0101, 1, 0, 1, "R3 K slot");
            if (d >= 0)
                feed(GT, 4'(d), 1, 0, 1, "R2 swept data group");
            else if (c == GI)
                feed(GT, 4'b0000, 0, 1, 0, "R5 idle closes frame");
            else
                feed(GT, 4'b1110, 1, 1, 1, "R6 invalid group in frame");
            feed(GR, 4'b0000, 0, 0, 0, "R4 R5 slot after sweep group");
            feed(GI, 4'b0000, 0, 0, 0, "R4 R slot");
            feed(GI, 4'b0000, 0, 0, 0, "R4 idle");
        end

        // R7: J followed by every code other than K
        for (int x = 0; x < 32; x++) begin
            logic [4:0] c;
            c = 5'(x);
            if (c != GK) begin
                feed(GJ, 4'b0000, 0, 0, 0, "R1 idle before J");
                feed(c, 4'b0000, 0, 1, 0, "R7 false carrier J slot");
                feed(GK, 4'b0000, 0, 0, 0, "R7 error lasts one slot");
                feed(GI, 4'b0000, 0, 0, 0, "R7 ignored group");
                feed(GI, 4'b0000, 0, 0, 0, "R7 back to idle");
            end
        end
        feed(GJ, 4'b0000, 0, 0, 0, "R7 idle before new J");
        feed(GK, 4'b0101, 1, 0, 1, "R7 frame after false carrier");
        feed(enc(9), 4'b0101, 1, 0, 1, "R3 K slot");

        // R8: stall inside a frame
        stall(5);
        feed(enc(3), 4'h9, 1, 0, 1, "R8 data after stall");
        stall(3);
        feed(GT, 4'h3, 1, 0, 1, "R8 data after second stall");
        feed(GR, 4'b0000, 0, 0, 0, "R4 T slot");
        feed(GI, 4'b0000, 0, 0, 0, "R4 R slot");

        // R1: reset in mid frame
        feed(GJ, 4'b0000, 0, 0, 0, "R1 idle before J");
        feed(GK, 4'b0101, 1, 0, 1, "R3 J slot");
        feed(enc(7), 4'b0101, 1, 0, 1, "R3 K slot");
        do_reset();
        feed(enc(2), 4'b0000, 0, 0, 0, "R1 pending cleared to idle");
        feed(GI, 4'b0000, 0, 0, 0, "R1 no frame after reset");

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule